// File: doc/BRIEF.md
# Multi-Bank GPIO Controller with Per-Pin Interrupt Sensing

This block controls a set of general-purpose I/O banks of 32 pins each and sits behind a plain register port made of an address, write data, a write strobe and a combinational read-data return. Software uses it to set each pin as an input or an output and to drive output values. It also reads back what every pin carries.

Each pin has its own interrupt sensing. Three per-pin type bits choose the mode: falling edge, rising edge, both edges, low level or high level. Pad inputs pass through a two-flop synchroniser. Edges are found by comparing the synchronised value with the value sampled one cycle earlier.

A detected event sets a sticky status bit, but only while that pin's enable bit is set. Software clears a status bit by writing a one to it. One interrupt line serves every bank, so software scans each bank's status register to find the pins that are pending.

Top module: `gpio_multibank`

## Requirements
- R1: After reset every register reads zero, `pad_oe` and `pad_out` are zero and `irq_out` is low.
- R2: Bank b occupies addresses b*0x40 to b*0x40+0x3F, and only word-aligned addresses with bits [1:0] = 0 are decoded. The register offsets within a bank are:
  - data at 0x00
  - direction at 0x04
  - enable at 0x20
  - type0 at 0x24
  - type1 at 0x28
  - type2 at 0x2C
  - status at 0x30

  Any other offset reads zero, and writing one bank leaves every other bank unchanged.
- R3: A direction bit of 1 makes that pin an output. `pad_oe` follows the direction register and `pad_out` follows the data latch, and neither changes without a register write.
- R4: A read of the data register returns the latched data bit for output pins and the synchronised pad value for input pins.
- R5: A pad change reaches detection through two synchroniser flops. A status bit for an edge is set on the third rising clock edge after the pad changes, and not before.
- R6: With type1=0 the pin is edge-sensed. With type2=1 both edges trigger whatever type0 holds. Otherwise type0=1 selects the rising edge and type0=0 the falling edge, so the reset value gives falling-edge sensing.
- R7: With type1=1 the pin is level-sensed: type0=1 selects high and type0=0 selects low. The status bit is set again on every cycle the level persists, and a set on the same cycle as a clear wins.
- R8: Writing a 1 to a status bit clears it and writing a 0 leaves it unchanged. Status bits fall only on a write.
- R9: A status bit is set only while its enable bit is 1. Events that occur while the pin is disabled are lost.
- R10: `irq_out` is the OR over all banks and pins of status AND enable. It is low whenever no status bit is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W (7) | Byte address: bank index in the upper bits, register in bits [5:2] |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| pad_in | input | NB*32 | Raw pad inputs, asynchronous |
| pad_out | output | NB*32 | Output data latch per pin |
| pad_oe | output | NB*32 | Output enable per pin (direction) |
| irq_out | output | 1 | Combined interrupt |

## Verification
The bench probes the status register one cycle before and on the cycle an edge should land. A design with one synchroniser flop too few or too many would set the bit early or late.

It clears a low-level pin while the level is still held and expects the bit to stay set. A design that gave the clear priority would read zero. It writes a word that clears only one of two pending bits, and a design treating zeros as clears would drop both.

It toggles a pin while that pin is disabled and then re-enables it. A design that latched events regardless of enable would report a stale status. It also drops enable while a status bit stays set, and `irq_out` must fall. Finally it raises a falling-edge event in the second bank to prove that the combined line and the bank decoding reach past bank zero.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int PINS      = 32;
    localparam int SPAN_BITS = 6;   // 64-byte window per bank

    // word index = byte offset [5:2]
    typedef enum logic [3:0] {
        REG_DATA = 4'h0,
        REG_DIR  = 4'h1,
        REG_EN   = 4'h8,
        REG_T0   = 4'h9,
        REG_T1   = 4'hA,
        REG_T2   = 4'hB,
        REG_STAT = 4'hC
    } reg_sel_e;

    typedef enum logic [2:0] {
        SENSE_FALL,
        SENSE_RISE,
        SENSE_BOTH,
        SENSE_LOW,
        SENSE_HIGH
    } sense_e;

    function automatic sense_e decode_sense(input logic t0, input logic t1, input logic t2);
        if (t1)      return t0 ? SENSE_HIGH : SENSE_LOW;
        else if (t2) return SENSE_BOTH;
        else         return t0 ? SENSE_RISE : SENSE_FALL;
    endfunction

endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q  <= '0;
            sync_out <= '0;
        end else begin
            stage_q  <= raw_in;
            sync_out <= stage_q;
        end
    end
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
    import gpio_irq_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cur,
    input  logic [W-1:0] enable,
    input  logic [W-1:0] type0,
    input  logic [W-1:0] type1,
    input  logic [W-1:0] type2,
    input  logic [W-1:0] clr,
    output logic [W-1:0] status
);
    logic [W-1:0] prev_q;
    logic [W-1:0] hit;

    for (genvar i = 0; i < W; i++) begin : g_pin
        sense_e mode;
        logic   ev;
        assign mode = decode_sense(type0[i], type1[i], type2[i]);
        always_comb begin
            unique case (mode)
                SENSE_FALL: ev = prev_q[i] & ~cur[i];
                SENSE_RISE: ev = ~prev_q[i] & cur[i];
                SENSE_BOTH: ev = prev_q[i] ^ cur[i];
                SENSE_LOW:  ev = ~cur[i];
                SENSE_HIGH: ev = cur[i];
                default:    ev = 1'b0;
            endcase
        end
        assign hit[i] = ev & enable[i];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            status <= '0;
        end else begin
            prev_q <= cur;
            status <= (status & ~clr) | hit;   // set wins over clear
        end
    end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_irq_pkg::*;
#(
    parameter int W = PINS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  reg_sel_e     rsel,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] pad_in,
    output logic [W-1:0] rdata,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_oe,
    output logic [W-1:0] status,
    output logic [W-1:0] enable
);
    logic [W-1:0] data_q, dir_q, en_q, t0_q, t1_q, t2_q;
    logic [W-1:0] sync_v;
    logic [W-1:0] clr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            dir_q  <= '0;
            en_q   <= '0;
            t0_q   <= '0;
            t1_q   <= '0;
            t2_q   <= '0;
        end else if (wr) begin
            unique case (rsel)
                REG_DATA: data_q <= wdata;
                REG_DIR:  dir_q  <= wdata;
                REG_EN:   en_q   <= wdata;
                REG_T0:   t0_q   <= wdata;
                REG_T1:   t1_q   <= wdata;
                REG_T2:   t2_q   <= wdata;
                default:  ;
            endcase
        end
    end

    assign clr = (wr && rsel == REG_STAT) ? wdata : '0;

    gpio_pin_sync #(.W(W)) u_sync (
        .clk(clk), .rst_n(rst_n), .raw_in(pad_in), .sync_out(sync_v)
    );

    gpio_irq_detect #(.W(W)) u_det (
        .clk(clk), .rst_n(rst_n), .cur(sync_v), .enable(en_q),
        .type0(t0_q), .type1(t1_q), .type2(t2_q), .clr(clr), .status(status)
    );

    always_comb begin
        unique case (rsel)
            REG_DATA: rdata = (dir_q & data_q) | (~dir_q & sync_v);
            REG_DIR:  rdata = dir_q;
            REG_EN:   rdata = en_q;
            REG_T0:   rdata = t0_q;
            REG_T1:   rdata = t1_q;
            REG_T2:   rdata = t2_q;
            REG_STAT: rdata = status;
            default:  rdata = '0;
        endcase
    end

    assign pad_out = data_q;
    assign pad_oe  = dir_q;
    assign enable  = en_q;
endmodule

// File: rtl/gpio_multibank.sv
module gpio_multibank
    import gpio_irq_pkg::*;
#(
    parameter  int NB     = 2,
    localparam int BANK_W = (NB > 1) ? $clog2(NB) : 1,
    localparam int ADDR_W = BANK_W + SPAN_BITS,
    localparam int TOT    = NB * PINS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_we,
    output logic [31:0]       bus_rdata,
    input  logic [TOT-1:0]    pad_in,
    output logic [TOT-1:0]    pad_out,
    output logic [TOT-1:0]    pad_oe,
    output logic              irq_out
);
    logic [BANK_W-1:0] bank_idx;
    logic              word_ok;
    reg_sel_e          rsel;
    logic [NB-1:0]     hit;
    logic [31:0]       bank_rd [NB];
    logic [TOT-1:0]    stat_all;
    logic [TOT-1:0]    en_all;

    assign bank_idx = bus_addr[ADDR_W-1:SPAN_BITS];
    assign word_ok  = (bus_addr[1:0] == 2'b00);
    assign rsel     = reg_sel_e'(bus_addr[SPAN_BITS-1:2]);

    for (genvar b = 0; b < NB; b++) begin : g_bank
        assign hit[b] = word_ok && (bank_idx == BANK_W'(b));
        gpio_bank #(.W(PINS)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr      (bus_we & hit[b]),
            .rsel    (rsel),
            .wdata   (bus_wdata),
            .pad_in  (pad_in[b*PINS +: PINS]),
            .rdata   (bank_rd[b]),
            .pad_out (pad_out[b*PINS +: PINS]),
            .pad_oe  (pad_oe[b*PINS +: PINS]),
            .status  (stat_all[b*PINS +: PINS]),
            .enable  (en_all[b*PINS +: PINS])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int b = 0; b < NB; b++) begin
            if (hit[b]) bus_rdata = bus_rdata | bank_rd[b];
        end
    end

    assign irq_out = |(stat_all & en_all);
endmodule

// File: rtl/gpio_multibank_chk.sv
module gpio_multibank_chk #(
    parameter int NB = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [NB*32-1:0]  pad_oe,
    input logic [NB*32-1:0]  pad_out,
    input logic [NB*32-1:0]  stat_all,
    input logic [NB*32-1:0]  en_all,
    input logic              irq_out
);
    // R3
    pad_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> ($stable(pad_oe) && $stable(pad_out)));

    // R8
    status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> ((~stat_all & $past(stat_all)) == '0));

    // R9
    set_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((stat_all & ~$past(stat_all) & ~$past(en_all)) == '0));

    // R10
    irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_all == '0) |-> !irq_out);

    // R10
    irq_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (en_all != '0));
endmodule

bind gpio_multibank gpio_multibank_chk #(.NB(NB)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .pad_oe(pad_oe),
    .pad_out(pad_out), .stat_all(stat_all), .en_all(en_all), .irq_out(irq_out)
);

// File: tb/gpio_multibank_bench.sv
`timescale 1ns/1ps
module gpio_multibank_bench;
    localparam int NB = 2;
    localparam int AW = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic          bus_we = 1'b0;
    logic [31:0]   bus_rdata;
    logic [63:0]   pad_in = '0;
    logic [63:0]   pad_out, pad_oe;
    logic          irq_out;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2 clk = ~clk;   // 250 MHz

    gpio_multibank #(.NB(NB)) u_gpio_multibank (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .irq_out(irq_out)
    );

    // kinds: 0 read data, 1 irq_out, 2 pad_oe bank0, 3 pad_out bank0, 4 pad_oe bank1
    typedef struct {
        int          kind;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb[$];
    bit    mon_pend = 0;

    always @(negedge clk) begin
        if (mon_pend && sb.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = sb.pop_front();
            unique case (it.kind)
                0: act = bus_rdata;
                1: act = {31'd0, irq_out};
                2: act = pad_oe[31:0];
                3: act = pad_out[31:0];
                default: act = pad_oe[63:32];
            endcase
            checks++;
            if (act !== it.exp) begin
                failures++;
                $display("FAIL %s: actual=%08h expected=%08h", it.tag, act, it.exp);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic probe(input int kind, input logic [AW-1:0] a,
                         input logic [31:0] e, input string tag);
        item_t it;
        @(posedge clk); #1;
        bus_addr = a;
        it.kind = kind; it.exp = e; it.tag = tag;
        sb.push_back(it);
        mon_pend = 1;
        @(posedge clk); #1;
        mon_pend = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        tick(4);
        rst_n = 1'b1;
        tick(1);

        // R1 reset state
        probe(0, 7'h00, 32'h0, "R1 data reset");
        probe(0, 7'h04, 32'h0, "R1 dir reset");
        probe(0, 7'h30, 32'h0, "R1 status reset");
        probe(1, 7'h00, 32'h0, "R1 irq reset");
        probe(2, 7'h00, 32'h0, "R1 pad_oe reset");

        // R3 / R4 direction and data mix
        pad_in[31:0] = 32'h1234_5600;
        wr(7'h04, 32'h0000_00FF);
        wr(7'h00, 32'hA5A5_A5A5);
        tick(3);
        probe(2, 7'h00, 32'h0000_00FF, "R3 pad_oe follows dir");
        probe(3, 7'h00, 32'hA5A5_A5A5, "R3 pad_out follows data");
        probe(0, 7'h00, 32'h1234_56A5, "R4 data read mix");

        // R2 bank isolation and unmapped offset
        probe(0, 7'h44, 32'h0, "R2 bank1 dir untouched");
        probe(4, 7'h00, 32'h0, "R2 bank1 pad_oe untouched");
        probe(0, 7'h10, 32'h0, "R2 unmapped offset reads zero");

        pad_in[31:0] = 32'h0;
        tick(3);

        // pin8 fall, pin9 rise, pin10 both, pin11 high, pin12 low
        wr(7'h24, 32'h0000_0A00);
        wr(7'h28, 32'h0000_1800);
        wr(7'h2C, 32'h0000_0400);
        probe(0, 7'h2C, 32'h0000_0400, "R2 type2 readback");
        wr(7'h20, 32'h0000_1F00);
        probe(0, 7'h30, 32'h0000_1000, "R7 low level sets status");
        probe(1, 7'h00, 32'h1, "R10 irq on pending");
        wr(7'h30, 32'h0000_1000);
        probe(0, 7'h30, 32'h0000_1000, "R7 level re-sets after clear");

        pad_in[12] = 1'b1;
        tick(3);
        wr(7'h30, 32'h0000_1000);
        probe(0, 7'h30, 32'h0, "R8 clear once level gone");

        // R5 / R6 rising edges
        pad_in[31:0] = 32'h0000_1700;
        tick(1);
        probe(0, 7'h30, 32'h0, "R5 not set before third edge");
        probe(0, 7'h30, 32'h0000_0600, "R6 rise and both on rising edge");
        wr(7'h30, 32'h0000_0200);
        probe(0, 7'h30, 32'h0000_0400, "R8 write zero keeps bit");
        wr(7'h30, 32'h0000_0400);
        probe(0, 7'h30, 32'h0, "R8 write one clears");

        // R6 falling edges
        pad_in[31:0] = 32'h0000_1000;
        tick(3);
        probe(0, 7'h30, 32'h0000_0500, "R6 fall and both on falling edge");
        wr(7'h30, 32'hFFFF_FFFF);
        probe(0, 7'h30, 32'h0, "R8 clear all");
        probe(1, 7'h00, 32'h0, "R10 irq low after clear");

        // R9 disabled events are lost
        wr(7'h20, 32'h0);
        pad_in[31:0] = 32'h0000_1200;
        tick(3);
        probe(0, 7'h30, 32'h0, "R9 no status while disabled");
        wr(7'h20, 32'h0000_1F00);
        probe(0, 7'h30, 32'h0, "R9 no stale event after enable");

        // R7 high level, R10 gated by enable
        pad_in[31:0] = 32'h0000_1A00;
        tick(3);
        probe(0, 7'h30, 32'h0000_0800, "R7 high level sets status");
        probe(1, 7'h00, 32'h1, "R10 irq high level");
        wr(7'h20, 32'h0);
        probe(0, 7'h30, 32'h0000_0800, "R8 status kept when disabled");
        probe(1, 7'h00, 32'h0, "R10 irq masked by enable");
        wr(7'h30, 32'h0000_0800);
        probe(0, 7'h30, 32'h0, "R9 no re-set while disabled");

        // R2 / R10 second bank
        wr(7'h60, 32'h0000_0001);
        pad_in[32] = 1'b1;
        tick(3);
        probe(0, 7'h70, 32'h0, "R6 default falling ignores rise");
        pad_in[32] = 1'b0;
        tick(3);
        probe(0, 7'h70, 32'h0000_0001, "R2 bank1 status");
        probe(0, 7'h30, 32'h0, "R2 bank0 status unaffected");
        probe(1, 7'h00, 32'h1, "R10 irq from bank1");
        wr(7'h70, 32'h0000_0001);
        probe(1, 7'h00, 32'h0, "R10 irq low after bank1 clear");

        tick(2);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule